// File: doc/BRIEF.md
# Supply Monitor and Write-Protect Logic

This block holds the digital decisions of a processor power supervisor. An ADC outside the block delivers the main supply and the backup battery voltage as millivolt codes, with a one-cycle strobe for each new sample. On every strobe the block runs two comparisons, each with hysteresis. The first checks the supply against a fixed reset trip point. The second checks the supply against the battery voltage, to decide whether the memory rail should run from the supply or from the battery.

From these two decisions the block drives a low-line flag, a battery-mode flag and a supply-good signal; the reset and watchdog timers use supply-good. It also gates a memory chip-enable and a power-fail warning. The chip-enable (active low) passes through only while the supply is healthy, and is held deasserted otherwise. The power-fail warning repeats an external comparator bit, except in battery mode, where it is held low. All outputs are registered.

Top module: `supply_guard`

## Requirements
- R1: When a strobed sample has the supply strictly below 4650 mV, `line_low` is 1 in the cycle after the strobe.
- R2: `line_low` returns to 0 only after a strobed sample with the supply strictly above 4690 mV (and not in battery mode). Samples from 4650 to 4690 mV inclusive leave the low-line decision unchanged.
- R3: A strobed sample with supply >= battery + 70 mV selects normal mode: `on_battery` is 0 in the cycle after the strobe.
- R4: A strobed sample with supply <= battery + 50 mV selects battery mode: `on_battery` is 1 in the cycle after the strobe. A supply between battery + 51 and battery + 69 mV keeps the previous mode.
- R5: `ce_n_out` (1 = deasserted) equals the `ce_n_in` of the previous cycle while `line_low` is 0. It is 1 whenever `line_low` or `on_battery` is 1, whatever `ce_n_in` is.
- R6: `pf_ok` equals the `pf_above` of the previous cycle (1 = monitored voltage above 1.3 V) while not in battery mode. No hysteresis is added. In battery mode `pf_ok` is 0 and `pf_above` is ignored.
- R7: In battery mode `line_low` is 1, whatever the supply code is.
- R8: `supply_good` is 1 exactly when `line_low` is 0 and `on_battery` is 0.
- R9: Both decisions change only on cycles where `smp_valid` is 1. New codes presented without the strobe have no effect on any output.
- R10: After `rst_n` is low, and until the first strobe, the outputs are `line_low`=1, `on_battery`=1, `ce_n_out`=1, `pf_ok`=0 and `supply_good`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe: the voltage codes are a new sample |
| vsup_mv | input | W | Main supply sample in millivolts |
| vbat_mv | input | W | Battery sample in millivolts |
| ce_n_in | input | 1 | Memory chip-enable request, active low |
| pf_above | input | 1 | Power-fail comparator bit, 1 = above 1.3 V |
| line_low | output | 1 | Low-line flag, 1 = supply below trip point or in battery mode |
| on_battery | output | 1 | Battery-mode flag |
| ce_n_out | output | 1 | Gated chip-enable, active low |
| pf_ok | output | 1 | Gated power-fail output, 0 = warning |
| supply_good | output | 1 | Supply usable: not low-line and not battery mode |

## Verification
On every cycle the assertions check the forced output set in battery mode, the one-cycle pass-through of the chip-enable and the power-fail bit, and the link between supply-good and the two flags. They also check that the flags hold still without a strobe, and that a sample below a trip point sets its flag. The scenarios alone show the hysteresis itself: a sample inside the 4650 to 4690 mV band, or inside the 50 to 70 mV switchover band, keeps whichever state came before. Showing this needs ordered sample sequences that approach each band from both sides. The exact boundary codes and the reset recovery are also checked by the bench only.

// File: rtl/sg_pkg.sv
package sg_pkg;

   // Registered output set of the supervisor
   typedef struct packed {
      logic line_low;
      logic on_battery;
      logic ce_n;
      logic pf_ok;
      logic good;
   } sg_out_t;

   // Safe state: what the block shows before any sample and in battery mode
   localparam sg_out_t SG_SAFE = '{line_low: 1'b1, on_battery: 1'b1,
                                   ce_n: 1'b1, pf_ok: 1'b0, good: 1'b0};

endpackage

// File: rtl/sg_hyst_cmp.sv
// Hysteretic comparator: the flag sets when the operand reaches ref+SET_OFS
// from above, and clears when it reaches ref+CLR_OFS from below.
module sg_hyst_cmp #(
   parameter int W         = 13,
   parameter int SET_OFS   = 0,
   parameter int CLR_OFS   = 40,
   parameter bit INCLUSIVE = 1'b0,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] opnd,
   input  logic [W-1:0] ref_v,
   output logic         flag_q,
   output logic         flag_nx
);
   localparam int EW = W + 1;

   generate
      if (CLR_OFS <= SET_OFS) begin : g_bad_ofs
         $error("sg_hyst_cmp: CLR_OFS must exceed SET_OFS");
      end
      if (W < 2) begin : g_bad_w
         $error("sg_hyst_cmp: W too small");
      end
   endgenerate

   logic [EW-1:0] opnd_x, set_lim, clr_lim;
   logic          hit_set, hit_clr;

   assign opnd_x  = {1'b0, opnd};
   assign set_lim = {1'b0, ref_v} + EW'(SET_OFS);
   assign clr_lim = {1'b0, ref_v} + EW'(CLR_OFS);

   generate
      if (INCLUSIVE) begin : g_incl
         assign hit_set = (opnd_x <= set_lim);
         assign hit_clr = (opnd_x >= clr_lim);
      end else begin : g_strict
         assign hit_set = (opnd_x < set_lim);
         assign hit_clr = (opnd_x > clr_lim);
      end
   endgenerate

   always_comb begin
      flag_nx = flag_q;
      if (upd) begin
         if (hit_set)      flag_nx = 1'b1;
         else if (hit_clr) flag_nx = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= RESET_VAL;
      else        flag_q <= flag_nx;
   end
endmodule

// File: rtl/sg_out_gate.sv
// Forces the safe output set in battery mode and gates the pass-through signals.
module sg_out_gate
   import sg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    low_nx,
   input  logic    bat_nx,
   input  logic    ce_n_in,
   input  logic    pf_above,
   output sg_out_t out_q
);
   sg_out_t out_nx;

   always_comb begin
      out_nx            = SG_SAFE;
      out_nx.on_battery = bat_nx;
      out_nx.line_low   = low_nx | bat_nx;
      out_nx.good       = ~(low_nx | bat_nx);
      out_nx.ce_n       = (low_nx | bat_nx) ? 1'b1 : ce_n_in;
      out_nx.pf_ok      = bat_nx ? 1'b0 : pf_above;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= SG_SAFE;
      else        out_q <= out_nx;
   end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
   import sg_pkg::*;
#(
   parameter int W          = 13,
   parameter int TRIP_MV    = 4650,
   parameter int HYST_MV    = 40,
   parameter int BAT_SET_MV = 50,
   parameter int BAT_CLR_MV = 70
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_valid,
   input  logic [W-1:0] vsup_mv,
   input  logic [W-1:0] vbat_mv,
   input  logic         ce_n_in,
   input  logic         pf_above,
   output logic         line_low,
   output logic         on_battery,
   output logic         ce_n_out,
   output logic         pf_ok,
   output logic         supply_good
);
   localparam int FULL_MV = (1 << W) - 1;

   generate
      if (TRIP_MV + HYST_MV > FULL_MV) begin : g_bad_trip
         $error("supply_guard: trip point does not fit in W bits");
      end
   endgenerate

   localparam logic [W-1:0] TRIP_CODE = W'(TRIP_MV);

   logic    low_q, low_nx, bat_q, bat_nx;
   sg_out_t out_q;

   // Reset trip point: strict compare on both edges of the band
   sg_hyst_cmp #(.W(W), .SET_OFS(0), .CLR_OFS(HYST_MV),
                 .INCLUSIVE(1'b0), .RESET_VAL(1'b1)) u_lowline (
      .clk(clk), .rst_n(rst_n), .upd(smp_valid),
      .opnd(vsup_mv), .ref_v(TRIP_CODE),
      .flag_q(low_q), .flag_nx(low_nx));

   // Battery switchover: inclusive compare against the battery sample
   sg_hyst_cmp #(.W(W), .SET_OFS(BAT_SET_MV), .CLR_OFS(BAT_CLR_MV),
                 .INCLUSIVE(1'b1), .RESET_VAL(1'b1)) u_switch (
      .clk(clk), .rst_n(rst_n), .upd(smp_valid),
      .opnd(vsup_mv), .ref_v(vbat_mv),
      .flag_q(bat_q), .flag_nx(bat_nx));

   sg_out_gate u_gate (
      .clk(clk), .rst_n(rst_n), .low_nx(low_nx), .bat_nx(bat_nx),
      .ce_n_in(ce_n_in), .pf_above(pf_above), .out_q(out_q));

   assign line_low    = out_q.line_low;
   assign on_battery  = out_q.on_battery;
   assign ce_n_out    = out_q.ce_n;
   assign pf_ok       = out_q.pf_ok;
   assign supply_good = out_q.good;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
   parameter int W          = 13,
   parameter int TRIP_MV    = 4650,
   parameter int BAT_SET_MV = 50
) (
   input logic         clk,
   input logic         rst_n,
   input logic         smp_valid,
   input logic [W-1:0] vsup_mv,
   input logic [W-1:0] vbat_mv,
   input logic         ce_n_in,
   input logic         pf_above,
   input logic         line_low,
   input logic         on_battery,
   input logic         ce_n_out,
   input logic         pf_ok,
   input logic         supply_good
);
   // R7
   bat_forces_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on_battery |-> (line_low && ce_n_out && !pf_ok));

   // R5
   ce_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_low |-> (ce_n_out == $past(ce_n_in)));

   // R6
   pf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !on_battery |-> (pf_ok == $past(pf_above)));

   // R8
   good_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_good |-> (!line_low && !on_battery));

   // R9
   hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(line_low) && $stable(on_battery)));

   // R1
   low_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && int'(vsup_mv) < TRIP_MV) |=> line_low);

   // R4
   bat_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && int'(vsup_mv) <= int'(vbat_mv) + BAT_SET_MV) |=> on_battery);
endmodule

bind supply_guard supply_guard_chk #(.W(W), .TRIP_MV(TRIP_MV), .BAT_SET_MV(BAT_SET_MV)) u_chk (.*);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
   localparam int W = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_valid = 1'b0;
   logic [W-1:0] vsup_mv = '0;
   logic [W-1:0] vbat_mv = '0;
   logic         ce_n_in = 1'b0;
   logic         pf_above = 1'b1;
   logic         line_low, on_battery, ce_n_out, pf_ok, supply_good;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   supply_guard u_supply_guard (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .vsup_mv(vsup_mv), .vbat_mv(vbat_mv), .ce_n_in(ce_n_in),
      .pf_above(pf_above), .line_low(line_low), .on_battery(on_battery),
      .ce_n_out(ce_n_out), .pf_ok(pf_ok), .supply_good(supply_good));

   // Expected vectors are {line_low, on_battery, ce_n_out, pf_ok, supply_good}
   localparam logic [4:0] SAFE   = 5'b11100;
   localparam logic [4:0] NORMAL = 5'b00011; // ce_n_in=0, pf_above=1
   localparam logic [4:0] LOWLN  = 5'b10110; // ce forced, pf passes

   task automatic check(input string tag, input logic [4:0] exp);
      logic [4:0] got;
      got = {line_low, on_battery, ce_n_out, pf_ok, supply_good};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // One strobed sample; outputs are checked one clock after the strobe edge
   task automatic sample(input int vs, input int vb);
      @(negedge clk);
      vsup_mv   = W'(vs);
      vbat_mv   = W'(vb);
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      check("R10 reset state", SAFE);
      repeat (3) @(negedge clk);
      check("R10 held until first sample", SAFE);
   endtask

   task automatic t_power_up();
      sample(5000, 3000);
      check("R3 R8 normal after first good sample", NORMAL);
   endtask

   task automatic t_passthrough();
      ce_n_in = 1'b1;
      @(negedge clk);
      check("R5 chip-enable follows input high", 5'b00111);
      ce_n_in = 1'b0;
      pf_above = 1'b0;
      @(negedge clk);
      check("R6 power-fail follows input low", 5'b00001);
      pf_above = 1'b1;
      @(negedge clk);
      check("R6 power-fail follows input high", NORMAL);
   endtask

   task automatic t_lowline_band();
      sample(4650, 3000);
      check("R1 exactly at trip point does not set", NORMAL);
      sample(4649, 3000);
      check("R1 below trip point sets low-line", LOWLN);
      ce_n_in = 1'b1;
      @(negedge clk);
      check("R5 chip-enable forced while low-line", LOWLN);
      ce_n_in = 1'b0;
      sample(4690, 3000);
      check("R2 top of band keeps low-line", LOWLN);
      sample(4691, 3000);
      check("R2 above band clears low-line", NORMAL);
      sample(4660, 3000);
      check("R2 inside band keeps cleared state", NORMAL);
   endtask

   task automatic t_switchover();
      sample(5000, 4900);
      check("R3 100 mV margin is normal", NORMAL);
      sample(4960, 4900);
      check("R4 60 mV margin keeps normal", NORMAL);
      sample(4950, 4900);
      check("R4 50 mV margin enters battery", SAFE);
      sample(4969, 4900);
      check("R4 69 mV margin keeps battery", SAFE);
      sample(4970, 4900);
      check("R3 70 mV margin returns to normal", NORMAL);
   endtask

   task automatic t_battery_ignores();
      sample(3000, 3000);
      check("R7 battery mode forces safe set", SAFE);
      pf_above = 1'b1;
      ce_n_in  = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 R5 inputs ignored in battery mode", SAFE);
      sample(4800, 4780);
      check("R7 low-line stays set above band in battery", SAFE);
      sample(5000, 3000);
      check("R3 recovery from battery", NORMAL);
   endtask

   task automatic t_no_strobe();
      @(negedge clk);
      vsup_mv = W'(3000);
      vbat_mv = W'(3000);
      repeat (4) @(negedge clk);
      check("R9 codes without strobe ignored", NORMAL);
      sample(4000, 3000);
      check("R9 R1 strobe applies held codes", LOWLN);
   endtask

   task automatic t_reset_again();
      sample(5000, 3000);
      check("R8 normal before reset", NORMAL);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset mid-run returns to safe set", SAFE);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 safe set kept after reset until sample", SAFE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_power_up();
      t_passthrough();
      t_lowline_band();
      t_switchover();
      t_battery_ignores();
      t_no_strobe();
      t_reset_again();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule